// File: doc/BRIEF.md
# Three-filter complex FIR tap line

This block is a short complex-valued FIR filter meant to sit in one frequency bin of a polyphase frequency-domain equalizer, between a parallel FFT and its matching IFFT. Each cycle it may accept one complex sample, tagged by a valid bit. It returns one filtered complex sample a fixed number of cycles later, tagged the same way.

The complex products are not formed tap by tap. The block splits the whole filter into three real FIR filters that share the input history. Filter A runs the sum of the real and imaginary input through the real coefficients. Filter B runs the imaginary input through the coefficient sums. Filter C runs the real input through the coefficient differences. The real output is A minus B and the imaginary output is A plus C. With four taps this needs 12 real multipliers and three 3-stage delay lines. The coefficient sums and differences arrive already computed, one bit wider than the base coefficients. Each tap has its own enable bit, so the impulse response can be shortened and the unused multipliers left idle.

Top module: `cfir3_tapline`

## Requirements
- R1: During and right after reset, out_valid is 0 and out_re and out_im are 0.
- R2: out_valid is asserted exactly 4 clock cycles after in_valid was sampled high, and never otherwise.
- R3: For each valid input sample n the output is y[n] = sum over enabled taps k of h[k]·x[n−k]. Here h[k] = coef_re[k] + j·(coef_sum[k] − coef_re[k]), tap k occupies bits [k·CW +: CW] (and [k·(CW+1) +: CW+1] for coef_sum and coef_dif), and x[n−k] is the k-th earlier valid sample, with samples older than reset taken as zero.
- R4: The full-precision result is scaled by 2^−SHIFT (default 7) with rounding half toward plus infinity, i.e. floor((acc + 2^(SHIFT−1)) / 2^SHIFT).
- R5: Scaled results outside [−2048, 2047] saturate to the nearest limit, separately for the real and imaginary parts.
- R6: A tap whose tap_en bit (bit k for tap k) is 0 contributes nothing to the output, and its product registers in all three filters read zero on the next cycle.
- R7: The sample history advances only on valid samples. Data presented while in_valid is 0 has no effect on any later output, and the history does not change.
- R8: out_re and out_im hold their last valid value while out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample qualifier |
| in_re | input | DW | Input real part, two's complement |
| in_im | input | DW | Input imaginary part, two's complement |
| coef_re | input | TAPS*CW | Real coefficient per tap |
| coef_sum | input | TAPS*(CW+1) | Real plus imaginary coefficient per tap |
| coef_dif | input | TAPS*(CW+1) | Imaginary minus real coefficient per tap |
| tap_en | input | TAPS | Per-tap enable |
| out_valid | output | 1 | Output sample qualifier |
| out_re | output | DW | Output real part, rounded and saturated |
| out_im | output | DW | Output imaginary part, rounded and saturated |

## Verification
The bench computes every output with a direct four-multiplier complex convolution over its own history of valid samples. It sweeps all sixteen tap-enable masks, so a design that mixes up the sign of the difference coefficient, or that lets a disabled tap leak, gives a wrong imaginary part or a wrong sum. Full-scale inputs against full-scale coefficients of every sign drive the results into both saturation limits, which exposes a sum that is too narrow or a clamp that wraps. Small inputs against a unit coefficient land on the half-way points of the rounding, so rounding toward zero or truncation would be off by one. Idle cycles carry garbage data, so a history that shifted on those cycles would corrupt the following outputs.

// File: rtl/cfir_pkg.sv
package cfir_pkg;

  // Arithmetic right shift of a wide value with rounding half toward +inf.
  function automatic logic signed [63:0] round_shift(input logic signed [63:0] v, input int sh);
    logic signed [63:0] half;
    if (sh <= 0) return v;
    half = 64'sd1 <<< (sh - 1);
    return (v + half) >>> sh;
  endfunction

  // Clamp a wide value into a signed range of ow bits.
  function automatic logic signed [63:0] clamp(input logic signed [63:0] v, input int ow);
    logic signed [63:0] top;
    logic signed [63:0] bot;
    top = (64'sd1 <<< (ow - 1)) - 64'sd1;
    bot = -(64'sd1 <<< (ow - 1));
    if (v > top) return top;
    if (v < bot) return bot;
    return v;
  endfunction

endpackage

// File: rtl/cfir_front.sv
module cfir_front #(
  parameter int DW   = 12,
  parameter int TAPS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [DW-1:0]             in_re,
  input  logic [DW-1:0]             in_im,
  output logic                      samp_valid,
  output logic [TAPS-1:0][DW:0]     sum_taps,
  output logic [TAPS-1:0][DW-1:0]   re_taps,
  output logic [TAPS-1:0][DW-1:0]   im_taps
);

  logic [DW-1:0] cur_re, cur_im;
  logic [DW:0]   cur_sum;
  logic [TAPS-1:1][DW-1:0] hist_re, hist_im;
  logic [TAPS-1:1][DW:0]   hist_sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_valid <= 1'b0;
      cur_re     <= '0;
      cur_im     <= '0;
      cur_sum    <= '0;
      hist_re    <= '0;
      hist_im    <= '0;
      hist_sum   <= '0;
    end else begin
      samp_valid <= in_valid;
      cur_re     <= in_re;
      cur_im     <= in_im;
      cur_sum    <= {in_re[DW-1], in_re} + {in_im[DW-1], in_im};
      if (samp_valid) begin
        hist_re[1]  <= cur_re;
        hist_im[1]  <= cur_im;
        hist_sum[1] <= cur_sum;
        for (int k = 2; k < TAPS; k++) begin
          hist_re[k]  <= hist_re[k-1];
          hist_im[k]  <= hist_im[k-1];
          hist_sum[k] <= hist_sum[k-1];
        end
      end
    end
  end

  assign sum_taps[0] = cur_sum;
  assign re_taps[0]  = cur_re;
  assign im_taps[0]  = cur_im;

  for (genvar k = 1; k < TAPS; k++) begin : g_tap
    assign sum_taps[k] = hist_sum[k];
    assign re_taps[k]  = hist_re[k];
    assign im_taps[k]  = hist_im[k];
  end

endmodule

// File: rtl/cfir_rfir.sv
module cfir_rfir #(
  parameter int TAPS = 4,
  parameter int IW   = 13,
  parameter int CW   = 8,
  parameter int PW   = IW + CW,
  parameter int FW   = PW + $clog2(TAPS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [TAPS-1:0][IW-1:0]  din,
  input  logic [TAPS-1:0][CW-1:0]  coef,
  input  logic [TAPS-1:0]          en,
  output logic [TAPS-1:0][PW-1:0]  prod_q,
  output logic signed [FW-1:0]     sum_q
);

  for (genvar k = 0; k < TAPS; k++) begin : g_mul
    logic signed [PW-1:0] dx, cx, px;
    logic [PW-1:0] p_r;
    assign dx = {{(PW-IW){din[k][IW-1]}}, din[k]};
    assign cx = {{(PW-CW){coef[k][CW-1]}}, coef[k]};
    assign px = dx * cx;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     p_r <= '0;
      else if (en[k]) p_r <= px;
      else            p_r <= '0;
    end
    assign prod_q[k] = p_r;
  end

  logic signed [FW-1:0] acc;
  always_comb begin
    acc = '0;
    for (int k = 0; k < TAPS; k++)
      acc = acc + {{(FW-PW){prod_q[k][PW-1]}}, prod_q[k]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else        sum_q <= acc;
  end

endmodule

// File: rtl/cfir_combine.sv
module cfir_combine #(
  parameter int FW    = 23,
  parameter int DW    = 12,
  parameter int SHIFT = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 v_in,
  input  logic signed [FW-1:0] fa,
  input  logic signed [FW-1:0] fb,
  input  logic signed [FW-1:0] fc,
  output logic                 out_valid,
  output logic [DW-1:0]        out_re,
  output logic [DW-1:0]        out_im
);
  import cfir_pkg::*;

  localparam int XW = FW + 1;

  logic signed [XW-1:0] yr, yi;
  logic signed [63:0]   yr64, yi64, qr, qi;

  assign yr   = {fa[FW-1], fa} - {fb[FW-1], fb};
  assign yi   = {fa[FW-1], fa} + {fc[FW-1], fc};
  assign yr64 = {{(64-XW){yr[XW-1]}}, yr};
  assign yi64 = {{(64-XW){yi[XW-1]}}, yi};
  assign qr   = clamp(round_shift(yr64, SHIFT), DW);
  assign qi   = clamp(round_shift(yi64, SHIFT), DW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
    end else begin
      out_valid <= v_in;
      if (v_in) begin
        out_re <= qr[DW-1:0];
        out_im <= qi[DW-1:0];
      end
    end
  end

endmodule

// File: rtl/cfir3_tapline.sv
module cfir3_tapline #(
  parameter int TAPS  = 4,
  parameter int DW    = 12,
  parameter int CW    = 8,
  parameter int SHIFT = CW - 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [DW-1:0]            in_re,
  input  logic [DW-1:0]            in_im,
  input  logic [TAPS*CW-1:0]       coef_re,
  input  logic [TAPS*(CW+1)-1:0]   coef_sum,
  input  logic [TAPS*(CW+1)-1:0]   coef_dif,
  input  logic [TAPS-1:0]          tap_en,
  output logic                     out_valid,
  output logic [DW-1:0]            out_re,
  output logic [DW-1:0]            out_im
);

  localparam int PW = DW + CW + 1;
  localparam int FW = PW + $clog2(TAPS);

  logic [TAPS-1:0][CW-1:0] cre;
  logic [TAPS-1:0][CW:0]   csum, cdif;
  assign cre  = coef_re;
  assign csum = coef_sum;
  assign cdif = coef_dif;

  logic                    samp_valid;
  logic [TAPS-1:0][DW:0]   sum_taps;
  logic [TAPS-1:0][DW-1:0] re_taps, im_taps;

  cfir_front #(.DW(DW), .TAPS(TAPS)) u_front (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .samp_valid(samp_valid), .sum_taps(sum_taps), .re_taps(re_taps), .im_taps(im_taps)
  );

  // Sample history only (tap 0 excluded), brought out for the checker.
  logic [(TAPS-1)*(3*DW+1)-1:0] hist_all;
  assign hist_all = {re_taps[TAPS-1:1], im_taps[TAPS-1:1], sum_taps[TAPS-1:1]};

  logic [TAPS-1:0][PW-1:0] prod_a, prod_b, prod_c;
  logic signed [FW-1:0]    f_a, f_b, f_c;

  cfir_rfir #(.TAPS(TAPS), .IW(DW+1), .CW(CW), .PW(PW), .FW(FW)) u_fa (
    .clk(clk), .rst_n(rst_n), .din(sum_taps), .coef(cre), .en(tap_en),
    .prod_q(prod_a), .sum_q(f_a)
  );

  cfir_rfir #(.TAPS(TAPS), .IW(DW), .CW(CW+1), .PW(PW), .FW(FW)) u_fb (
    .clk(clk), .rst_n(rst_n), .din(im_taps), .coef(csum), .en(tap_en),
    .prod_q(prod_b), .sum_q(f_b)
  );

  cfir_rfir #(.TAPS(TAPS), .IW(DW), .CW(CW+1), .PW(PW), .FW(FW)) u_fc (
    .clk(clk), .rst_n(rst_n), .din(re_taps), .coef(cdif), .en(tap_en),
    .prod_q(prod_c), .sum_q(f_c)
  );

  logic v_prod, v_sum;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_prod <= 1'b0;
      v_sum  <= 1'b0;
    end else begin
      v_prod <= samp_valid;
      v_sum  <= v_prod;
    end
  end

  cfir_combine #(.FW(FW), .DW(DW), .SHIFT(SHIFT)) u_comb (
    .clk(clk), .rst_n(rst_n), .v_in(v_sum), .fa(f_a), .fb(f_b), .fc(f_c),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
  );

endmodule

// File: rtl/cfir3_chk.sv
module cfir3_chk #(
  parameter int TAPS = 4,
  parameter int DW   = 12,
  parameter int CW   = 8,
  localparam int PW  = DW + CW + 1,
  localparam int HW  = (TAPS-1)*(3*DW+1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               samp_valid,
  input logic               out_valid,
  input logic [DW-1:0]      out_re,
  input logic [DW-1:0]      out_im,
  input logic [TAPS-1:0]    tap_en,
  input logic [HW-1:0]      hist_bits,
  input logic [TAPS*PW-1:0] pa,
  input logic [TAPS*PW-1:0] pb,
  input logic [TAPS*PW-1:0] pc
);

  logic [2:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cyc <= '0;
    else if (cyc != 7)  cyc <= cyc + 3'd1;
  end

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd4) |-> (out_valid == $past(in_valid, 4)));

  // R7
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 3'd0 && !samp_valid) |=> $stable(hist_bits));

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 3'd0 && !out_valid) |-> ($stable(out_re) && $stable(out_im)));

  for (genvar k = 0; k < TAPS; k++) begin : g_off
    // R6
    tap_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tap_en[k] |=> (pa[k*PW +: PW] == '0 && pb[k*PW +: PW] == '0 && pc[k*PW +: PW] == '0));
  end

endmodule

bind cfir3_tapline cfir3_chk #(.TAPS(TAPS), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .samp_valid(samp_valid),
  .out_valid(out_valid), .out_re(out_re), .out_im(out_im), .tap_en(tap_en),
  .hist_bits(hist_all), .pa(prod_a), .pb(prod_b), .pc(prod_c)
);

// File: tb/test_cfir3_tapline.sv
`timescale 1ns/1ps
module test_cfir3_tapline;

  localparam int TAPS = 4;
  localparam int DW   = 12;
  localparam int CW   = 8;
  localparam int QN   = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_re = '0, in_im = '0;
  logic [TAPS*CW-1:0]     coef_re = '0;
  logic [TAPS*(CW+1)-1:0] coef_sum = '0, coef_dif = '0;
  logic [TAPS-1:0]        tap_en = '0;
  logic out_valid;
  logic [DW-1:0] out_re, out_im;

  always #10 clk = ~clk;

  cfir3_tapline i_cfir3_tapline (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .coef_re(coef_re), .coef_sum(coef_sum), .coef_dif(coef_dif), .tap_en(tap_en),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
  );

  int errors = 0, checks = 0, cyc = 0;
  int cr[TAPS], ci[TAPS];
  int hx_r[TAPS], hx_i[TAPS];
  int exp_r[QN], exp_i[QN], exp_due[QN];
  string exp_tag[QN];
  int wr = 0, rd = 0;
  int last_r = 0, last_i = 0;
  string cur_tag = "R3";
  int unsigned seed = 32'h1234_5678;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int scale(longint a);
    longint q, d;
    q = a + 64;
    if (q >= 0) d = q / 128;
    else        d = -((-q + 127) / 128);
    if (d > 2047)  return 2047;
    if (d < -2048) return -2048;
    return int'(d);
  endfunction

  function automatic int rnd(int lo, int hi);
    seed = seed * 32'd1103515245 + 32'd12345;
    return lo + int'((seed >> 8) % (hi - lo + 1));
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic set_coef();
    logic [8:0] s9, d9;
    logic [7:0] r8;
    for (int k = 0; k < TAPS; k++) begin
      r8 = 8'(cr[k]);
      s9 = 9'(cr[k] + ci[k]);
      d9 = 9'(ci[k] - cr[k]);
      coef_re[k*CW +: CW]        = r8;
      coef_sum[k*(CW+1) +: CW+1] = s9;
      coef_dif[k*(CW+1) +: CW+1] = d9;
    end
  endtask

  task automatic send(bit v, int r, int i);
    longint ar, ai;
    @(negedge clk);
    in_valid = v;
    in_re = 12'(r);
    in_im = 12'(i);
    if (v) begin
      for (int k = TAPS-1; k > 0; k--) begin
        hx_r[k] = hx_r[k-1];
        hx_i[k] = hx_i[k-1];
      end
      hx_r[0] = r;
      hx_i[0] = i;
      ar = 0; ai = 0;
      for (int k = 0; k < TAPS; k++) if (tap_en[k]) begin
        ar += longint'(hx_r[k]) * cr[k] - longint'(hx_i[k]) * ci[k];
        ai += longint'(hx_i[k]) * cr[k] + longint'(hx_r[k]) * ci[k];
      end
      exp_r[wr % QN]   = scale(ar);
      exp_i[wr % QN]   = scale(ai);
      exp_due[wr % QN] = cyc + 4;
      exp_tag[wr % QN] = cur_tag;
      wr++;
    end
  endtask

  task automatic idle(int n);
    for (int j = 0; j < n; j++) send(1'b0, rnd(-2048, 2047), rnd(-2048, 2047));
  endtask

  // Output monitor, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && cyc > 0) begin
      if (out_valid) begin
        if (rd == wr) begin
          check(1'b0, "R2", "unexpected out_valid", 1, 0);
        end else begin
          check(exp_due[rd % QN] == cyc, "R2", "output cycle", cyc, exp_due[rd % QN]);
          check(int'($signed(out_re)) == exp_r[rd % QN], exp_tag[rd % QN], "real part",
                int'($signed(out_re)), exp_r[rd % QN]);
          check(int'($signed(out_im)) == exp_i[rd % QN], exp_tag[rd % QN], "imag part",
                int'($signed(out_im)), exp_i[rd % QN]);
          last_r = int'($signed(out_re));
          last_i = int'($signed(out_im));
          rd++;
        end
      end else begin
        if (rd != wr && exp_due[rd % QN] <= cyc)
          check(1'b0, "R2", "missing out_valid", 0, 1);
        check(int'($signed(out_re)) == last_r && int'($signed(out_im)) == last_i, "R8",
              "hold while idle", int'($signed(out_re)), last_r);
      end
    end
  end

  initial begin
    #(20 * 150000);
    check(1'b0, "watchdog", "run timed out", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < TAPS; k++) begin hx_r[k] = 0; hx_i[k] = 0; cr[k] = 0; ci[k] = 0; end
    repeat (3) @(negedge clk);
    // R1: state during reset
    check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    check(out_re == '0 && out_im == '0, "R1", "data in reset", int'(out_re), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    check(out_re == '0 && out_im == '0, "R1", "data after reset", int'(out_im), 0);

    // R3: impulse response read back through all taps
    cur_tag = "R3";
    cr = '{20, -35, 60, -90}; ci = '{-7, 44, -100, 127};
    tap_en = 4'hF; set_coef();
    send(1'b1, 128, 0);
    for (int j = 0; j < 5; j++) send(1'b1, 0, 0);
    send(1'b1, 0, 128);
    for (int j = 0; j < 5; j++) send(1'b1, 0, 0);
    idle(6);

    // R3, R6: every tap-enable mask with random coefficients and data
    for (int m = 0; m < 16; m++) begin
      cur_tag = (m == 15) ? "R3" : "R6";
      for (int k = 0; k < TAPS; k++) begin cr[k] = rnd(-128, 127); ci[k] = rnd(-128, 127); end
      tap_en = 4'(m); set_coef();
      for (int j = 0; j < 12; j++) send(1'b1, rnd(-2048, 2047), rnd(-2048, 2047));
      idle(6);
    end

    // R7, R8: gaps with garbage data between valid samples
    cur_tag = "R7";
    tap_en = 4'hF;
    for (int k = 0; k < TAPS; k++) begin cr[k] = rnd(-128, 127); ci[k] = rnd(-128, 127); end
    set_coef();
    for (int j = 0; j < 20; j++) begin
      send(1'b1, rnd(-2048, 2047), rnd(-2048, 2047));
      idle(1 + (j % 3));
    end
    idle(6);

    // R5: full-scale data against full-scale coefficients of every sign
    cur_tag = "R5";
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < TAPS; k++) begin
        cr[k] = (s[0]) ? -128 : 127;
        ci[k] = (s[1]) ? -128 : 127;
      end
      set_coef();
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++) begin
          int va, vb;
          va = (a == 0) ? -2048 : (a == 1) ? 2047 : (a == 2) ? 0 : -1;
          vb = (b == 0) ? -2048 : (b == 1) ? 2047 : (b == 2) ? 0 : -1;
          send(1'b1, va, vb);
          send(1'b1, va, vb);
        end
      idle(6);
    end

    // R4: unit coefficient on tap 0 puts inputs on rounding half-points
    cur_tag = "R4";
    cr = '{1, 0, 0, 0}; ci = '{0, 0, 0, 0};
    tap_en = 4'b0001; set_coef();
    send(1'b1, 64, -64);
    send(1'b1, 63, -65);
    send(1'b1, 191, -192);
    send(1'b1, -1, 1);
    send(1'b1, 2047, -2048);
    send(1'b1, -63, 65);
    idle(8);

    check(rd == wr, "R2", "all outputs delivered", rd, wr);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule